// File: doc/BRIEF.md
# Divided Countdown Timer with One-Shot and Periodic Modes

This block counts down from a programmed start value at a rate derived from its input clock. A small register port sets the clock divider, the start value and a control entry that holds the interrupt vector, a mask flag and the mode flag. A further port address reads back the live count. Each time the count reaches zero the block emits a one-cycle request carrying the vector from the control entry, unless the mask flag is set. In one-shot mode it then halts at zero. In periodic mode it reloads the start value on the following tick and repeats.

The divider is a free-running prescaler that yields one tick every 2^shift input cycles. Writing the start value reloads the count and clears the prescaler, so the timing always begins at that write. A start value of zero halts the timer. The counter is run by a three-state machine. `ST_STOP` means no count is loaded. `ST_RUN` means the count is decrementing, or waiting at zero for a periodic reload. `ST_EXPIRED` means a one-shot count has finished. The transitions are:

- STOP to RUN: a nonzero start value is written.
- RUN to EXPIRED: a tick arrives at count 1, or at count 0, while the mode flag selects one-shot.
- Any state to RUN: a nonzero start value is written.
- Any state to STOP: a zero start value is written.

Top module: `tick_timer`

## Requirements
- R1: A write to the divider register (address 3) stores only bits 0, 1 and 3 of the write data. Every other bit reads back as zero. The reset value is 0.
- R2: The 3-bit divide code is {cfg[3], cfg[1], cfg[0]}. shift = (code + 1) mod 8, and the count advances once every 2^shift clock cycles. Divider value 0xB therefore ticks every cycle, 0x0 every 2 cycles, 0x3 every 16 cycles and 0x8 every 32 cycles.
- R3: A write to the start register (address 1) loads the count and restarts the prescaler. After the write edge, the first decrement occurs exactly 2^shift cycles later. The count is unchanged between ticks.
- R4: In one-shot mode (control bit 17 = 0), a start value N with write edge W reaches zero on edge W + N*2^shift. The count then holds at 0, and exactly one request is raised.
- R5: In periodic mode (control bit 17 = 1), the count runs N, N-1, …, 0 and then reloads N, for a period of N+1 ticks. Requests appear on edges W + (N + k(N+1))*2^shift.
- R6: A request is a single-cycle high on `irq_valid`, driven from the edge on which the count becomes 0. `irq_vector` carries control bits [7:0].
- R7: While control bit 16 (mask) is 1, no request is raised, but counting proceeds as usual. The reset value of the control entry is 0x0001_0000 (masked).
- R8: Writing a start value of 0 halts the timer. The count reads 0 and no request follows.
- R9: The current-count register (address 2) is read-only. Writing to it leaves the count unchanged.
- R10: Reads are combinational on `reg_addr`. Address 0 returns the control entry: vector in bits [7:0], mask in bit 16, mode in bit 17, all other bits zero. Address 1 returns the start value. Address 2 returns the live count. Address 3 returns the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
The bench builds the block with CNT_W = 16 and DATA_W = 32. A 16-bit count is wide enough to check that a one-shot count ends up holding at zero, and small enough that short periodic runs fit in a few hundred cycles. Four divider settings are run: divide by 1, 2, 16 and 32. These cover the wrap of code 7 to a shift of zero, the plain reset divider and the case where config bit 3 supplies code bit 2. Each setting puts the first decrement and the request on an exactly predictable edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;

    localparam logic [1:0] A_ENTRY = 2'd0;
    localparam logic [1:0] A_INIT  = 2'd1;
    localparam logic [1:0] A_CUR   = 2'd2;
    localparam logic [1:0] A_DIV   = 2'd3;

    localparam int VEC_W    = 8;
    localparam int MASK_BIT = 16;
    localparam int PER_BIT  = 17;
    localparam int SHIFT_W  = 3;
    localparam int DIVCFG_W = 4;

    // Divide code {cfg[3], cfg[1:0]}; the shift is code+1, wrapping within 3 bits.
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIVCFG_W-1:0] cfg);
        logic [SHIFT_W-1:0] code;
        code = {cfg[3], cfg[1:0]};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_timer_pkg::*;
#(
    parameter int PRE_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;

    // Bits below the shift must all be one for a tick.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            low_mask[i] = (i < int'(shift));
        end
    end

    assign tick = &(pre_q | ~low_mask);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // A restart clears the prescaler, so the next cycle can tick only at a shift of zero.
    assert_restart_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && $stable(shift)) |=> (tick == (shift == '0)));

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [CNT_W-1:0]    cur_count,
    output logic [DATA_W-1:0]   rdata,
    output logic [VEC_W-1:0]    vector,
    output logic                masked,
    output logic                periodic,
    output logic [SHIFT_W-1:0]  shift,
    output logic [CNT_W-1:0]    init_val,
    output logic                load
);

    localparam logic [DIVCFG_W-1:0] DIV_KEEP = 4'hB;

    logic [DIVCFG_W-1:0] div_q;
    logic [VEC_W-1:0]    vec_q;
    logic                mask_q;
    logic                per_q;
    logic [CNT_W-1:0]    init_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            vec_q  <= '0;
            mask_q <= 1'b1;
            per_q  <= 1'b0;
            init_q <= '0;
        end else if (wr) begin
            unique case (addr)
                A_ENTRY: begin
                    vec_q  <= wdata[VEC_W-1:0];
                    mask_q <= wdata[MASK_BIT];
                    per_q  <= wdata[PER_BIT];
                end
                A_INIT:  init_q <= wdata[CNT_W-1:0];
                A_DIV:   div_q  <= wdata[DIVCFG_W-1:0] & DIV_KEEP;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_ENTRY: begin
                rdata[VEC_W-1:0] = vec_q;
                rdata[MASK_BIT]  = mask_q;
                rdata[PER_BIT]   = per_q;
            end
            A_INIT:  rdata[CNT_W-1:0]    = init_q;
            A_CUR:   rdata[CNT_W-1:0]    = cur_count;
            A_DIV:   rdata[DIVCFG_W-1:0] = div_q;
            default: rdata = '0;
        endcase
    end

    assign vector   = vec_q;
    assign masked   = mask_q;
    assign periodic = per_q;
    assign shift    = div_shift(div_q);
    assign load     = wr && (addr == A_INIT);
    assign init_val = wdata[CNT_W-1:0];

    assert_div_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_DIV) |=> (div_q[2] == 1'b0));

endmodule

// File: rtl/tick_count_fsm.sv
module tick_count_fsm
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   init_val,
    input  logic               tick,
    input  logic               periodic,
    input  logic               masked,
    input  logic [VEC_W-1:0]   vector,
    output logic [CNT_W-1:0]   count,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q;
    logic             hit;
    logic             irq_q;
    logic [VEC_W-1:0] vec_out_q;

    assign hit = (state_q == ST_RUN) && tick && !load && (count_q == ONE);

    // Next state and next count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (load) begin
            count_d = init_val;
            state_d = (init_val == '0) ? ST_STOP : ST_RUN;
        end else begin
            unique case (state_q)
                ST_STOP: begin
                    count_d = '0;
                end
                ST_RUN: begin
                    if (tick) begin
                        if (count_q == '0) begin
                            if (periodic) begin
                                count_d = reload_q;
                            end else begin
                                state_d = ST_EXPIRED;
                            end
                        end else begin
                            count_d = count_q - ONE;
                            if (count_q == ONE && !periodic) begin
                                state_d = ST_EXPIRED;
                            end
                        end
                    end
                end
                ST_EXPIRED: begin
                    count_d = '0;
                end
                default: begin
                    state_d = ST_STOP;
                    count_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_STOP;
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (load) begin
                reload_q <= init_val;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            vec_out_q <= '0;
        end else begin
            irq_q <= hit && !masked;
            if (hit) begin
                vec_out_q <= vector;
            end
        end
    end

    assign count      = count_q;
    assign irq_valid  = irq_q;
    assign irq_vector = vec_out_q;

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    assert_irq_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (count == '0));

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !load) |=> !irq_valid);

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && $stable(masked)) |=> !irq_valid);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [7:0]        irq_vector
);

    logic [CNT_W-1:0]   count;
    logic [VEC_W-1:0]   vector;
    logic               masked;
    logic               periodic;
    logic [SHIFT_W-1:0] shift;
    logic [CNT_W-1:0]   init_val;
    logic               load;
    logic               tick;

    tick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cur_count (count),
        .rdata     (reg_rdata),
        .vector    (vector),
        .masked    (masked),
        .periodic  (periodic),
        .shift     (shift),
        .init_val  (init_val),
        .load      (load)
    );

    tick_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (shift),
        .tick    (tick)
    );

    tick_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .init_val   (init_val),
        .tick       (tick),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (vector),
        .count      (count),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    assert_cur_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CUR && !tick) |=> $stable(count));

endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_valid;
    logic [7:0]        irq_vector;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    int          exp_cyc[$];
    logic [7:0]  exp_vec[$];

    always #2.5 clk = ~clk;

    tick_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares each request against the expected queue.
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            n_checks++;
            if (exp_cyc.size() == 0) begin
                n_fail++;
                $display("FAIL R6: actual request at cycle %0d expected none", cyc);
            end else begin
                int ec;
                logic [7:0] ev;
                ec = exp_cyc.pop_front();
                ev = exp_vec.pop_front();
                if (ec != cyc || ev !== irq_vector) begin
                    n_fail++;
                    $display("FAIL R4/R5/R6: actual cycle %0d vec 0x%0h expected cycle %0d vec 0x%0h",
                             cyc, irq_vector, ec, ev);
                end
            end
        end
    end

    // Driver: one write, returns the cycle index of its edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        w = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_irq(input int c, input logic [7:0] v);
        exp_cyc.push_back(c);
        exp_vec.push_back(v);
    endtask

    initial begin
        int w;
        int w2;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(2'd0, v); check("R7 reset entry", v, 32'h0001_0000);
        rd(2'd2, v); check("R8 reset count", v, 32'h0);
        rd(2'd3, v); check("R1 reset divider", v, 32'h0);
        check("R6 reset irq", {31'b0, irq_valid}, 32'h0);

        // R1: only bits 0,1,3 kept
        wr(2'd3, 32'hFFFF_FFFF, w);
        rd(2'd3, v); check("R1 divider mask", v, 32'hB);

        // R10: control entry layout
        wr(2'd0, 32'hFFFC_FF41, w);
        rd(2'd0, v); check("R10 entry readback", v, 32'h0000_0041);

        // R4: one-shot, divide by 1 (0xB), N=5
        wr(2'd1, 32'd5, w);
        expect_irq(w + 5, 8'h41);
        rd(2'd2, v); check("R3 loaded count", v, 32'd5);
        rd(2'd1, v); check("R10 start readback", v, 32'd5);
        wait_until(w + 2);
        rd(2'd2, v); check("R2 divide-by-1 count", v, 32'd3);
        // R9: write to current count ignored (tick occurs on this edge)
        wr(2'd2, 32'h0000_ABCD, w2);
        rd(2'd2, v); check("R9 read-only count", v, 32'd5 - 32'(w2 - w));
        wait_until(w + 20);
        rd(2'd2, v); check("R4 hold at zero", v, 32'd0);

        // R2/R3: divide by 2 (cfg 0), N=3
        wr(2'd3, 32'h0, w);
        wr(2'd0, 32'h0000_0022, w);
        wr(2'd1, 32'd3, w);
        expect_irq(w + 6, 8'h22);
        wait_until(w + 1);
        rd(2'd2, v); check("R3 no early tick", v, 32'd3);
        wait_until(w + 2);
        rd(2'd2, v); check("R3 first tick after 2", v, 32'd2);
        wait_until(w + 12);

        // R2: divide by 16 (cfg 0x3), N=2
        wr(2'd3, 32'h3, w);
        wr(2'd1, 32'd2, w);
        expect_irq(w + 32, 8'h22);
        wait_until(w + 15);
        rd(2'd2, v); check("R2 div16 before tick", v, 32'd2);
        wait_until(w + 16);
        rd(2'd2, v); check("R2 div16 at tick", v, 32'd1);
        wait_until(w + 40);

        // R2: divide by 32 (cfg 0x8 -> code 4), N=1
        wr(2'd3, 32'h8, w);
        wr(2'd1, 32'd1, w);
        expect_irq(w + 32, 8'h22);
        wait_until(w + 31);
        rd(2'd2, v); check("R2 div32 before tick", v, 32'd1);
        wait_until(w + 40);

        // R5: periodic, divide by 1, N=2
        wr(2'd3, 32'hB, w);
        wr(2'd0, 32'h0002_0077, w);
        wr(2'd1, 32'd2, w);
        expect_irq(w + 2, 8'h77);
        expect_irq(w + 5, 8'h77);
        expect_irq(w + 8, 8'h77);
        wait_until(w + 3);
        rd(2'd2, v); check("R5 reload after zero", v, 32'd2);
        wait_until(w + 8);
        // R8: start value 0 halts
        wr(2'd1, 32'd0, w2);
        rd(2'd2, v); check("R8 stopped count", v, 32'd0);
        wait_until(w2 + 20);
        rd(2'd2, v); check("R8 still zero", v, 32'd0);

        // R7: masked one-shot counts but stays quiet
        wr(2'd0, 32'h0001_0055, w);
        wr(2'd1, 32'd4, w);
        wait_until(w + 2);
        rd(2'd2, v); check("R7 masked still counts", v, 32'd2);
        wait_until(w + 10);
        rd(2'd2, v); check("R7 masked reaches zero", v, 32'd0);

        // R3: rewrite while running restarts
        wr(2'd0, 32'h0000_0099, w);
        wr(2'd1, 32'd10, w);
        wait_until(w + 3);
        wr(2'd1, 32'd4, w2);
        expect_irq(w2 + 4, 8'h99);
        rd(2'd2, v); check("R3 restart load", v, 32'd4);
        wait_until(w2 + 30);

        check("R4 all expected requests seen", 32'(exp_cyc.size()), 32'd0);
        done = 1;
    end

    initial begin
        while (!done && cyc < 100000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule